// File: doc/BRIEF.md
# Fractional M/N Audio Clock Generator

The block produces an audio bit-clock from one of four source tick lines, using a rational M/N accumulator. On every tick of the chosen source the accumulator grows by M. Each time it reaches N, it drops by N and the block emits a one-cycle enable pulse. Over time the pulse rate is the source tick rate scaled by M/N. A second output, a square wave, flips on every pulse, so it runs at half the pulse rate with a duty cycle as even as the ratio allows.

All four sources reach the block as single-cycle tick strobes in one fast clock domain, and the selection is a plain index into those strobes. Software sets up the block through one 32-bit control word, which can be read back. The bit positions are fixed:

- bits 31:30: source index
- bit 29: run enable
- bits 28:20: numerator M, 9 bits
- bits 19:0: denominator N, 20 bits

A ratio is accepted only when M ≥ 1, N ≥ 2 and N ≥ 2·M. With those limits the output never goes above half the source rate. For an exact integer division, use M = 1 and N equal to the division ratio. A ratio written while the block runs waits in a shadow copy and takes effect at the next accumulator wrap, so no short pulse can appear.

Top module: `mnclk_gen`

## Requirements
- R1: After reset the control word reads 0x00100002 (source 0, disabled, M = 1, N = 2). Every write updates the source index (31:30) and the enable (29), and a legal write also updates M (28:20) and N (19:0). Reads show these accepted values.
- R2: Once the enable is set, with the accumulator starting from zero, the number of pulses after k selected ticks is floor(k·M/N).
- R3: With M = 1 the pulses fall exactly on every N-th selected tick, starting with tick N.
- R4: Only the tick line whose index matches bits 31:30 advances the accumulator. Ticks on the other lines produce no pulse.
- R5: A write with M = 0, N < 2 or N < 2·M leaves the stored ratio unchanged. Its source index and enable still take effect, and the block keeps running with the old ratio.
- R6: `cfgErr` is low after reset. An illegal ratio write sets it, and it stays set through later legal writes until the next reset.
- R7: `clkOut` is low after reset and after a disable. It inverts on each pulse and changes at no other time.
- R8: One clock after the enable reads clear, `tickOut` and `clkOut` are low and stay low whatever ticks arrive. The next enable starts again from an accumulator of zero.
- R9: A legal ratio written while running takes effect at the next wrap. That wrap still ends the old period, and the accumulator then restarts from zero with the new ratio.
- R10: `tickOut` is one clock wide, appears only in the clock after a selected tick, and two pulses are never adjacent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock; all source ticks are synchronous to it |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 32 | Control word write value |
| rdData | output | 32 | Control word readback |
| srcTick | input | 4 | One tick strobe per selectable source |
| tickOut | output | 1 | Single-cycle output clock-enable pulse |
| clkOut | output | 1 | Square wave toggling on each pulse |
| cfgErr | output | 1 | Sticky flag for a rejected ratio |

## Verification
The ratio is exercised with several kinds of setting, each of which separates a different class of fault:

- Whole divisions with M = 1 catch off-by-one errors in the wrap compare.
- Ratios with remainders, such as 3/8, 5/17 and 2/5, show whether the remainder is carried or dropped.
- The half-rate extreme 511/1022 and the very sparse 7/1000 check the width limits of the accumulator.

Running the same ratios on sources of different tick density, while the unselected lines keep ticking, shows whether the selection really isolates one line. Recording the exact tick positions of the pulses around a ratio change separates the held-until-wrap update from an immediate one.

// File: rtl/mnclk_pkg.sv
package mnclk_pkg;
  // Strobes from the control half to the accumulator datapath
  typedef struct packed {
    logic run;      // enable bit as stored
    logic tick;     // selected source tick this cycle
    logic load;     // take the offered ratio into the active copy
    logic restart;  // on a wrap, clear the accumulator instead of keeping the remainder
  } dpStrobe_t;
endpackage

// File: rtl/mnclk_ctrl.sv
module mnclk_ctrl
  import mnclk_pkg::*;
#(
  parameter int M_W   = 9,
  parameter int N_W   = 20,
  parameter int N_SRC = 4,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int REG_W = SEL_W + 1 + M_W + N_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic [N_SRC-1:0] srcTick,
  input  logic             wrapNow,
  output dpStrobe_t        stb,
  output logic [M_W-1:0]   ratioM,
  output logic [N_W-1:0]   ratioN,
  output logic [REG_W-1:0] rdData,
  output logic             cfgErr
);
  localparam int EN_BIT = M_W + N_W;
  localparam int PAD_W  = N_W - M_W;

  logic [SEL_W-1:0] selQ;
  logic             enQ;
  logic [M_W-1:0]   mQ, mD;
  logic [N_W-1:0]   nQ, nD;
  logic             pendQ, errQ;
  logic [M_W-1:0]   wM;
  logic [N_W-1:0]   wN;
  logic [N_W:0]     twoM;
  logic             legal, validWr;

  always_comb begin
    wM      = wrData[N_W +: M_W];
    wN      = wrData[N_W-1:0];
    twoM    = {{PAD_W{1'b0}}, wM, 1'b0};
    legal   = (wM != '0) && (wN >= N_W'(2)) && ({1'b0, wN} >= twoM);
    validWr = wrEn && legal;
    mD      = validWr ? wM : mQ;
    nD      = validWr ? wN : nQ;
  end

  // Shadow values that will be stored after this edge are what the datapath may load
  assign ratioM = mD;
  assign ratioN = nD;

  always_comb begin
    stb.run     = enQ;
    stb.tick    = srcTick[selQ];
    stb.restart = pendQ || (validWr && enQ);
    stb.load    = !enQ || (wrapNow && stb.restart);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= '0;
      enQ   <= 1'b0;
      mQ    <= M_W'(1);
      nQ    <= N_W'(2);
      pendQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      if (wrEn) begin
        selQ <= wrData[REG_W-1 -: SEL_W];
        enQ  <= wrData[EN_BIT];
        if (!legal) errQ <= 1'b1;
      end
      mQ    <= mD;
      nQ    <= nD;
      pendQ <= enQ && (pendQ || validWr) && !wrapNow;
    end
  end

  assign rdData = {selQ, enQ, mQ, nQ};
  assign cfgErr = errQ;
endmodule

// File: rtl/mnclk_datapath.sv
module mnclk_datapath
  import mnclk_pkg::*;
#(
  parameter int M_W = 9,
  parameter int N_W = 20,
  localparam int ACC_W = N_W + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpStrobe_t      stb,
  input  logic [M_W-1:0] ratioM,
  input  logic [N_W-1:0] ratioN,
  output logic           wrapNow,
  output logic           tickOut,
  output logic           clkOut
);
  logic [M_W-1:0]   actM;
  logic [N_W-1:0]   actN;
  logic [ACC_W-1:0] acc, sum;

  always_comb begin
    sum     = acc + ACC_W'(actM);
    wrapNow = stb.run && stb.tick && (sum >= ACC_W'(actN));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actM <= M_W'(1);
      actN <= N_W'(2);
    end else if (stb.load) begin
      actM <= ratioM;
      actN <= ratioN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !stb.run) begin
      acc     <= '0;
      tickOut <= 1'b0;
      clkOut  <= 1'b0;
    end else if (stb.tick) begin
      if (wrapNow) begin
        acc    <= stb.restart ? '0 : sum - ACC_W'(actN);
        clkOut <= !clkOut;
      end else begin
        acc <= sum;
      end
      tickOut <= wrapNow;
    end else begin
      tickOut <= 1'b0;
    end
  end
endmodule

// File: rtl/mnclk_gen.sv
module mnclk_gen
  import mnclk_pkg::*;
#(
  parameter int M_W   = 9,
  parameter int N_W   = 20,
  parameter int N_SRC = 4,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int REG_W = SEL_W + 1 + M_W + N_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic [N_SRC-1:0] srcTick,
  output logic             tickOut,
  output logic             clkOut,
  output logic             cfgErr
);
  dpStrobe_t      stb;
  logic [M_W-1:0] ratioM;
  logic [N_W-1:0] ratioN;
  logic           wrapNow;

  mnclk_ctrl #(.M_W(M_W), .N_W(N_W), .N_SRC(N_SRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .srcTick(srcTick),
    .wrapNow(wrapNow), .stb(stb), .ratioM(ratioM), .ratioN(ratioN),
    .rdData(rdData), .cfgErr(cfgErr)
  );

  mnclk_datapath #(.M_W(M_W), .N_W(N_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ratioM(ratioM), .ratioN(ratioN),
    .wrapNow(wrapNow), .tickOut(tickOut), .clkOut(clkOut)
  );
endmodule

// File: rtl/mnclk_gen_chk.sv
module mnclk_gen_chk #(
  parameter int M_W   = 9,
  parameter int N_W   = 20,
  parameter int N_SRC = 4,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int REG_W = SEL_W + 1 + M_W + N_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic [REG_W-1:0] rdData,
  input logic [N_SRC-1:0] srcTick,
  input logic             tickOut,
  input logic             clkOut,
  input logic             cfgErr
);
  localparam int EN_BIT = M_W + N_W;

  logic [M_W-1:0]   chkM;
  logic [N_W-1:0]   chkN;
  logic             badWr;
  logic [SEL_W-1:0] curSel;

  always_comb begin
    chkM   = wrData[N_W +: M_W];
    chkN   = wrData[N_W-1:0];
    badWr  = wrEn && ((chkM == '0) || (chkN < N_W'(2)) ||
             ((N_W + 1)'(chkN) < ((N_W + 1)'(chkM) << 1)));
    curSel = rdData[REG_W-1 -: SEL_W];
  end

  // R10
  no_double_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |=> !tickOut);

  // R4
  no_tick_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !srcTick[curSel] |=> !tickOut);

  // R7
  toggle_on_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> (clkOut != $past(clkOut)));

  // R7
  toggle_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkOut != $past(clkOut)) |-> (tickOut || !clkOut));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[EN_BIT] |=> (!tickOut && !clkOut));

  // R5
  bad_ratio_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    badWr |=> (rdData[EN_BIT-1:0] == $past(rdData[EN_BIT-1:0])));

  // R6
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    badWr |=> cfgErr);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);
endmodule

bind mnclk_gen mnclk_gen_chk #(.M_W(M_W), .N_W(N_W), .N_SRC(N_SRC)) u_chk (.*);

// File: tb/mnclk_gen_tb.sv
module mnclk_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 8;
  // sel, M, N, window length in cycles
  localparam int VEC [N_VEC][4] = '{
    '{0, 1, 4, 40},   '{0, 3, 8, 64},  '{1, 5, 17, 100}, '{2, 1, 2, 30},
    '{3, 7, 20, 80},  '{0, 511, 1022, 30}, '{0, 2, 5, 33}, '{0, 7, 1000, 1000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  srcTick = '0;
  logic        tickOut, clkOut, cfgErr;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD / 2) clk = !clk;

  mnclk_gen u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .srcTick(srcTick), .tickOut(tickOut), .clkOut(clkOut), .cfgErr(cfgErr)
  );

  function automatic logic [31:0] mk(int s, int e, int m, int n);
    logic [1:0]  sv = s[1:0];
    logic        ev = e[0];
    logic [8:0]  mv = m[8:0];
    logic [19:0] nv = n[19:0];
    return {sv, ev, mv, nv};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wrReg(logic [31:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Each source i ticks on cycles where c % (i+1) == 0
  task automatic runWindow(int len, output int cnt, output logic [31:0] mask);
    cnt = 0;
    mask = '0;
    for (int c = 0; c < len; c++) begin
      for (int i = 0; i < 4; i++) srcTick[i] = ((c % (i + 1)) == 0);
      @(negedge clk);
      if (tickOut) begin
        cnt++;
        if (c < 32) mask[c] = 1'b1;
      end
    end
    srcTick = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt, ticks, expCnt;
    logic [31:0] mask;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset word", rdData, 32'h0010_0002);
    check("R7 reset clkOut", {31'd0, clkOut}, 32'd0);
    check("R10 reset tickOut", {31'd0, tickOut}, 32'd0);
    check("R6 reset cfgErr", {31'd0, cfgErr}, 32'd0);

    // Table of ratio / source vectors
    for (int v = 0; v < N_VEC; v++) begin
      wrReg(mk(VEC[v][0], 0, VEC[v][1], VEC[v][2]));
      check("R1 readback", rdData, mk(VEC[v][0], 0, VEC[v][1], VEC[v][2]));
      repeat (2) @(negedge clk);
      wrReg(mk(VEC[v][0], 1, VEC[v][1], VEC[v][2]));
      runWindow(VEC[v][3], cnt, mask);
      ticks  = (VEC[v][3] + VEC[v][0]) / (VEC[v][0] + 1);
      expCnt = ticks * VEC[v][1] / VEC[v][2];
      check(VEC[v][0] != 0 ? "R4 pulse count on selected source" : "R2 pulse count",
            cnt, expCnt);
      check("R7 clkOut parity", {31'd0, clkOut}, expCnt & 1);
      wrReg(mk(0, 0, 1, 2));
    end

    // R3: exact division by 3 on every-cycle source
    repeat (2) @(negedge clk);
    wrReg(mk(0, 1, 1, 3));
    runWindow(12, cnt, mask);
    check("R3 pulse positions", mask, 32'h924);
    check("R10 pulse positions isolated", mask & (mask << 1), 32'h0);
    wrReg(mk(0, 0, 1, 3));

    // R4: selected line silent while the others tick
    wrReg(mk(1, 1, 1, 2));
    cnt = 0;
    for (int c = 0; c < 20; c++) begin
      srcTick = 4'b1101;
      @(negedge clk);
      if (tickOut) cnt++;
    end
    srcTick = '0;
    check("R4 unselected ticks ignored", cnt, 0);
    wrReg(mk(0, 0, 1, 2));

    // R9: ratio change while running waits for the wrap
    repeat (2) @(negedge clk);
    wrReg(mk(0, 1, 1, 4));
    mask = '0;
    for (int c = 0; c < 12; c++) begin
      srcTick = 4'b0001;
      if (c == 5) begin
        wrEn = 1'b1;
        wrData = mk(0, 1, 1, 2);
      end else begin
        wrEn = 1'b0;
      end
      @(negedge clk);
      if (tickOut) mask[c] = 1'b1;
    end
    wrEn = 1'b0;
    srcTick = '0;
    check("R9 held ratio pulse positions", mask, 32'hA88);
    check("R9 readback new ratio", rdData, mk(0, 1, 1, 2));

    // R8: disable while running
    wrReg(mk(0, 0, 1, 4));
    repeat (2) @(negedge clk);
    wrReg(mk(0, 1, 1, 4));
    runWindow(6, cnt, mask);
    check("R7 clkOut high after one pulse", {31'd0, clkOut}, 32'd1);
    srcTick = 4'hF;
    wrReg(mk(0, 0, 1, 4));
    @(negedge clk);
    check("R8 clkOut low after disable", {31'd0, clkOut}, 32'd0);
    cnt = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (tickOut || clkOut) cnt++;
    end
    srcTick = '0;
    check("R8 quiet while disabled", cnt, 0);
    wrReg(mk(0, 1, 1, 4));
    runWindow(4, cnt, mask);
    check("R8 restart from zero", mask, 32'h8);
    wrReg(mk(0, 0, 1, 4));

    // R5 / R6: illegal ratios
    check("R6 no error before bad write", {31'd0, cfgErr}, 32'd0);
    wrReg(mk(1, 0, 3, 5));
    check("R5 N<2M ratio kept, sel applied", rdData, mk(1, 0, 1, 4));
    check("R6 error set", {31'd0, cfgErr}, 32'd1);
    wrReg(mk(0, 0, 0, 8));
    check("R5 M=0 ratio kept", rdData, mk(0, 0, 1, 4));
    wrReg(mk(0, 0, 1, 1));
    check("R5 N<2 ratio kept", rdData, mk(0, 0, 1, 4));
    wrReg(mk(0, 0, 1, 2));
    check("R1 legal write after error", rdData, mk(0, 0, 1, 2));
    check("R6 error stays set", {31'd0, cfgErr}, 32'd1);
    wrReg(mk(0, 0, 1, 4));
    repeat (2) @(negedge clk);
    wrReg(mk(0, 1, 3, 5));
    check("R5 enable applied, ratio kept", rdData, mk(0, 1, 1, 4));
    runWindow(20, cnt, mask);
    check("R5 runs with old ratio", cnt, 5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule